// File: doc/BRIEF.md
# Asynchronous Serial Transceiver

This block moves bytes between a CPU and a one-bit asynchronous serial line. It has one byte of transmit buffering in front of a transmit shifter. On the receive side, a receive shifter fills a one-byte receive buffer. The CPU side has three actions: write a byte into the transmit buffer, read the receive buffer, and look at a 7-bit status word. The serial line runs on an external enable pulse at sixteen times the bit rate, so each bit occupies sixteen enable ticks. The line idles at mark (logic 1), and data goes out least significant bit first.

A 2-bit mode input selects where the serial streams go:
- **Normal:** the transmitter drives the pin and the pin feeds the receiver.
- **Forced break:** the output pin is held at space.
- **Echo:** the incoming line is copied back out.
- **Internal loopback:** the transmit stream feeds the receiver and the pin stays at mark.

Each received character is checked for parity, framing, overrun and break. All error flags are refreshed at the moment the stop bit is sampled.

Top module: `async_xcvr`

## Requirements
- R1: While reset is held, and after it is released, status reads 7'b1100000 and serial_out is mark in normal mode. The status fields are: bit0 data-ready, bit1 overrun, bit2 framing, bit3 parity, bit4 break, bit5 transmission-complete, bit6 buffer-empty.
- R2: A character on the line is, in order: a start bit of 0, the data bits least significant first, an optional parity bit, and one stop bit of 1. Every bit lasts 16 ticks of tick16.
- R3: Buffer-empty drops on the clock edge that takes a write. It rises on the next edge, when an idle shifter takes the byte. Transmission-complete is high only when both the buffer and the shifter are empty.
- R4: The receiver checks a falling edge again 8 ticks later and drops it if the line is back at mark. After that, it samples each bit 16 ticks apart. In loopback with tick16 held high, data-ready rises 154 clocks after the write edge, or 170 clocks with parity enabled.
- R5: rd_data shows the receive buffer. A read pulse clears data-ready on the next edge.
- R6: If a character completes while data-ready is still set, overrun is set and the buffer keeps the unread character.
- R7: A stop bit sampled as 0 sets the framing flag.
- R8: With parity enabled, the expected parity bit is the XOR of the data bits, inverted when parity_odd is 1. A received parity bit that differs sets the parity flag.
- R9: A character that is all zero, including its parity and stop bits, sets the break flag. It also sets framing, loads the buffer with 0x00 and raises data-ready.
- R10: The overrun, framing, parity and break flags change only at stop-bit sampling, where each one is rewritten for the new character.
- R11: Mode 2'b01 holds serial_out at 0.
- R12: Mode 2'b10 copies serial_in to serial_out two clocks later.
- R13: Mode 2'b11 holds serial_out at mark, ignores serial_in, and sends the transmit stream to the receiver.
- R14: With rx_enable low, the receiver sees a steady mark, so no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| mode | input | 2 | 00 normal, 01 forced break, 10 echo, 11 loopback |
| rx_enable | input | 1 | Receiver input gate |
| parity_en | input | 1 | Adds a parity bit to both directions |
| parity_odd | input | 1 | Selects odd parity when 1 |
| wr_en | input | 1 | Writes wr_data into the transmit buffer |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Read of the receive buffer, clears data-ready |
| rd_data | output | DATA_W | Receive buffer contents |
| status | output | 7 | Status word (fields in R1) |
| serial_in | input | 1 | Serial line input |
| serial_out | output | 1 | Serial line output |

## Verification
The bench holds tick16 high, so one bit lasts sixteen clocks and every result has a known due cycle:
- **Transmit buffer:** buffer-empty falls one edge after the write and rises again on the following edge.
- **Transmitted bits:** bit k is on the pin from clock 16k+2 to 16k+17 after the write edge.
- **Loopback receive:** data-ready rises on clock 154 (170 with parity). The bench checks it low one clock before that and high on the due clock.
- **External receive:** characters on serial_in go through a two-stage input synchronizer. The bench therefore checks the flags twenty clocks after the stop bit ends, which is past the due cycle with margin.
- **Sampling:** all values are sampled on the falling clock edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_BREAK  = 2'b01,
    MODE_ECHO   = 2'b10,
    MODE_LOOP   = 2'b11
  } xcvr_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  localparam int STAT_W     = 7;
  localparam int ST_READY   = 0;
  localparam int ST_OVR     = 1;
  localparam int ST_FRM     = 2;
  localparam int ST_PAR     = 3;
  localparam int ST_BRK     = 4;
  localparam int ST_TXDONE  = 5;
  localparam int ST_BEMPTY  = 6;

endpackage

// File: rtl/xcvr_tx.sv
module xcvr_tx
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              tx_line,
  output logic              buf_empty,
  output logic              tx_done
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(OVS);
  localparam int BITS_W  = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(OVS - 1);
  localparam logic [BITS_W-1:0] BITS_PAR  = BITS_W'(DATA_W + 3);
  localparam logic [BITS_W-1:0] BITS_NOPAR = BITS_W'(DATA_W + 2);

  logic [DATA_W-1:0]  buf_q, buf_n;
  logic               full_q, full_n;
  logic               busy_q, busy_n;
  logic [FRAME_W-1:0] shreg_q, shreg_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [BITS_W-1:0]  left_q, left_n;
  logic               load;
  logic               pbit;

  // next-state logic
  always_comb begin
    buf_n   = buf_q;
    full_n  = full_q;
    busy_n  = busy_q;
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    left_n  = left_q;
    load    = full_q && !busy_q;
    pbit    = (^buf_q) ^ par_odd;

    if (load) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      if (par_en) begin
        shreg_n = {1'b1, pbit, buf_q, 1'b0};
        left_n  = BITS_PAR;
      end else begin
        shreg_n = {2'b11, buf_q, 1'b0};
        left_n  = BITS_NOPAR;
      end
    end else if (busy_q && tick) begin
      if (cnt_q == CNT_LAST) begin
        cnt_n   = '0;
        shreg_n = {1'b1, shreg_q[FRAME_W-1:1]};
        left_n  = left_q - 1'b1;
        if (left_q == BITS_W'(1)) busy_n = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end

    if (wr_en) begin
      buf_n  = wr_data;
      full_n = 1'b1;
    end else if (load) begin
      full_n = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      busy_q  <= 1'b0;
      shreg_q <= '1;
      cnt_q   <= '0;
      left_q  <= '0;
    end else begin
      buf_q   <= buf_n;
      full_q  <= full_n;
      busy_q  <= busy_n;
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
      left_q  <= left_n;
    end
  end

  assign tx_line   = busy_q ? shreg_q[0] : 1'b1;
  assign buf_empty = !full_q;
  assign tx_done   = !full_q && !busy_q;

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty); // R3

  AST_BUF_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !busy_q && !wr_en) |=> (busy_q && buf_empty)); // R3

endmodule

// File: rtl/xcvr_rx.sv
module xcvr_rx
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_ready,
  output logic              err_ovr,
  output logic              err_frm,
  output logic              err_par,
  output logic              err_brk
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] shreg_q, shreg_n;
  logic              parb_q, parb_n;
  logic [DATA_W-1:0] rbuf_q, rbuf_n;
  logic              dr_q, dr_n;
  logic              ovr_q, ovr_n;
  logic              frm_q, frm_n;
  logic              per_q, per_n;
  logic              brk_q, brk_n;
  logic              stop_hit;
  logic              exp_par;

  // next-state logic
  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    idx_n    = idx_q;
    shreg_n  = shreg_q;
    parb_n   = parb_q;
    rbuf_n   = rbuf_q;
    dr_n     = dr_q;
    ovr_n    = ovr_q;
    frm_n    = frm_q;
    per_n    = per_q;
    brk_n    = brk_q;
    stop_hit = 1'b0;
    exp_par  = (^shreg_q) ^ par_odd;

    case (state_q)
      RX_IDLE: begin
        if (tick && !line) begin
          state_n = RX_START;
          cnt_n   = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == CNT_HALF) begin
            cnt_n = '0;
            idx_n = '0;
            state_n = line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_n   = '0;
            shreg_n = {line, shreg_q[DATA_W-1:1]};
            if (idx_q == IDX_LAST) state_n = par_en ? RX_PAR : RX_STOP;
            else                   idx_n   = idx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      RX_PAR: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_n   = '0;
            parb_n  = line;
            state_n = RX_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_n    = '0;
            stop_hit = 1'b1;
            state_n  = RX_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: state_n = RX_IDLE;
    endcase

    if (stop_hit) begin
      frm_n = !line;
      per_n = par_en && (parb_q != exp_par);
      brk_n = !line && (shreg_q == '0) && (!par_en || !parb_q);
      if (dr_q && !rd_en) begin
        ovr_n = 1'b1;
      end else begin
        ovr_n  = 1'b0;
        rbuf_n = shreg_q;
        dr_n   = 1'b1;
      end
    end else if (rd_en) begin
      dr_n = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      parb_q  <= 1'b0;
      rbuf_q  <= '0;
      dr_q    <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      per_q   <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      shreg_q <= shreg_n;
      parb_q  <= parb_n;
      rbuf_q  <= rbuf_n;
      dr_q    <= dr_n;
      ovr_q   <= ovr_n;
      frm_q   <= frm_n;
      per_q   <= per_n;
      brk_q   <= brk_n;
    end
  end

  assign rx_data    = rbuf_q;
  assign data_ready = dr_q;
  assign err_ovr    = ovr_q;
  assign err_frm    = frm_q;
  assign err_par    = per_q;
  assign err_brk    = brk_q;

  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !stop_hit) |=> !data_ready); // R5

  AST_OVERRUN_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovr) |-> $stable(rx_data)); // R6

  AST_BREAK_HAS_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    err_brk |-> err_frm); // R9

  AST_FLAGS_AT_STOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_hit |=> $stable({err_ovr, err_frm, err_par, err_brk})); // R10

endmodule

// File: rtl/async_xcvr.sv
module async_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic [1:0]        mode,
  input  logic              rx_enable,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [6:0]        status,
  input  logic              serial_in,
  output logic              serial_out
);

  logic [1:0]             rst_q;
  logic                   core_rst_n;
  logic [SYNC_STAGES-1:0] sin_q;
  logic                   sin_sync;
  xcvr_mode_e             mode_e;
  logic                   tx_line;
  logic                   rx_src;
  logic                   rx_line;
  logic                   buf_empty;
  logic                   tx_done;
  logic                   dr, ovr, frm, per, brk;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign core_rst_n = rst_q[1];

  // serial input synchronizer, resets to mark
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) sin_q <= '1;
    else             sin_q <= {sin_q[SYNC_STAGES-2:0], serial_in};
  end
  assign sin_sync = sin_q[SYNC_STAGES-1];

  assign mode_e  = xcvr_mode_e'(mode);
  assign rx_src  = (mode_e == MODE_LOOP) ? tx_line : sin_sync;
  assign rx_line = rx_enable ? rx_src : 1'b1;

  always_comb begin
    case (mode_e)
      MODE_NORMAL: serial_out = tx_line;
      MODE_BREAK:  serial_out = 1'b0;
      MODE_ECHO:   serial_out = sin_sync;
      default:     serial_out = 1'b1;
    endcase
  end

  xcvr_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick      (tick16),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .par_en    (parity_en),
    .par_odd   (parity_odd),
    .tx_line   (tx_line),
    .buf_empty (buf_empty),
    .tx_done   (tx_done)
  );

  xcvr_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tick       (tick16),
    .line       (rx_line),
    .par_en     (parity_en),
    .par_odd    (parity_odd),
    .rd_en      (rd_en),
    .rx_data    (rd_data),
    .data_ready (dr),
    .err_ovr    (ovr),
    .err_frm    (frm),
    .err_par    (per),
    .err_brk    (brk)
  );

  always_comb begin
    status             = '0;
    status[ST_READY]   = dr;
    status[ST_OVR]     = ovr;
    status[ST_FRM]     = frm;
    status[ST_PAR]     = per;
    status[ST_BRK]     = brk;
    status[ST_TXDONE]  = tx_done;
    status[ST_BEMPTY]  = buf_empty;
  end

endmodule

// File: tb/async_xcvr_bench.sv
`timescale 1ns/1ps
module async_xcvr_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick16;
  logic [1:0] mode;
  logic       rx_enable, parity_en, parity_odd;
  logic       wr_en, rd_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [6:0] status;
  logic       serial_in;
  logic       serial_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  async_xcvr u_async_xcvr (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .mode(mode),
    .rx_enable(rx_enable), .parity_en(parity_en), .parity_odd(parity_odd),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .status(status), .serial_in(serial_in), .serial_out(serial_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_byte();
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit pe, input bit po,
                            input bit flip, input bit stopv);
    logic [11:0] f;
    int n;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = d[i];
    n = 9;
    if (pe) begin f[9] = (^d) ^ po ^ flip; n = 10; end
    f[n] = stopv;
    n++;
    for (int i = 0; i < n; i++) begin
      serial_in = f[i];
      repeat (16) @(negedge clk);
    end
    serial_in = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(3);
    chk("R1 status in reset", status, 7'b1100000);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 status after reset", status, 7'b1100000);
    chk("R1 serial_out mark", serial_out, 1);
  endtask

  task automatic t_tx_frame();
    logic [10:0] exp;
    mode = 2'b00; parity_en = 1'b1; parity_odd = 1'b0;
    exp = {1'b1, 1'b0, 8'hA5, 1'b0};
    write_byte(8'hA5);
    cyc(9);
    for (int k = 0; k < 11; k++) begin
      chk($sformatf("R2 tx bit %0d", k), serial_out, exp[k]);
      if (k < 10) cyc(16);
    end
    cyc(20);
    chk("R2 tx idle mark", serial_out, 1);
    chk("R3 tx done after frame", status[5], 1);
    parity_en = 1'b0;
  endtask

  task automatic t_loop(input logic [7:0] d, input bit pe, input bit po);
    int lat;
    lat = pe ? 170 : 154;
    mode = 2'b11; parity_en = pe; parity_odd = po;
    serial_in = 1'b0;
    write_byte(d);
    chk("R3 empty low after write", status[6], 0);
    chk("R3 tx done low after write", status[5], 0);
    cyc(1);
    chk("R3 empty high after handoff", status[6], 1);
    chk("R3 tx done low while shifting", status[5], 0);
    for (int k = 2; k <= lat - 1; k++) begin
      cyc(1);
      if (k % 16 == 0) chk("R13 loop pin at mark", serial_out, 1);
    end
    chk("R4 ready not before due cycle", status[0], 0);
    cyc(1);
    chk("R4 ready on due cycle", status[0], 1);
    chk("R13 loop data", rd_data, d);
    chk("R13 loop no errors", status[4:1], 0);
    cyc(20);
    chk("R3 tx done after shifter empty", status[5], 1);
    read_byte();
    chk("R5 ready cleared by read", status[0], 0);
    chk("R5 rd_data holds byte", rd_data, d);
    serial_in = 1'b1;
    cyc(5);
    mode = 2'b00; parity_en = 1'b0; parity_odd = 1'b0;
  endtask

  task automatic t_rx_good();
    send_frame(8'h5A, 0, 0, 0, 1);
    chk("R2 rx data", rd_data, 8'h5A);
    chk("R2 rx ready", status[0], 1);
    chk("R2 rx no errors", status[4:1], 0);
    read_byte();
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 0, 0, 0, 1);
    send_frame(8'h22, 0, 0, 0, 1);
    chk("R6 overrun flag", status[1], 1);
    chk("R6 buffer keeps first", rd_data, 8'h11);
    chk("R6 ready still set", status[0], 1);
    read_byte();
    chk("R5 ready cleared", status[0], 0);
  endtask

  task automatic t_framing();
    send_frame(8'h3C, 0, 0, 0, 0);
    chk("R7 framing flag", status[2], 1);
    chk("R7 break clear", status[4], 0);
    chk("R10 overrun refreshed", status[1], 0);
    chk("R7 data loaded", rd_data, 8'h3C);
    read_byte();
  endtask

  task automatic t_parity();
    parity_en = 1'b1; parity_odd = 1'b0;
    send_frame(8'h07, 1, 0, 1, 1);
    chk("R8 even parity error", status[3], 1);
    chk("R10 framing refreshed", status[2], 0);
    read_byte();
    parity_odd = 1'b1;
    send_frame(8'h07, 1, 1, 0, 1);
    chk("R8 odd parity good", status[3], 0);
    chk("R8 odd data", rd_data, 8'h07);
    read_byte();
    parity_en = 1'b0; parity_odd = 1'b0;
  endtask

  task automatic t_break();
    send_frame(8'h00, 0, 0, 0, 0);
    chk("R9 break flag", status[4], 1);
    chk("R9 framing with break", status[2], 1);
    chk("R9 ready on break", status[0], 1);
    chk("R9 break data", rd_data, 0);
    read_byte();
    send_frame(8'hC3, 0, 0, 0, 1);
    chk("R10 flags cleared by good char", status[4:1], 0);
    chk("R10 data", rd_data, 8'hC3);
    read_byte();
  endtask

  task automatic t_echo();
    mode = 2'b10;
    serial_in = 1'b0;
    cyc(1);
    chk("R12 echo not yet", serial_out, 1);
    cyc(1);
    chk("R12 echo low", serial_out, 0);
    serial_in = 1'b1;
    cyc(2);
    chk("R12 echo high", serial_out, 1);
    cyc(40);
    chk("R4 short pulse rejected in echo", status[0], 0);
    mode = 2'b00;
  endtask

  task automatic t_glitch();
    serial_in = 1'b0;
    cyc(6);
    serial_in = 1'b1;
    cyc(40);
    chk("R4 glitch rejected", status[0], 0);
  endtask

  task automatic t_rx_disable();
    rx_enable = 1'b0;
    send_frame(8'h55, 0, 0, 0, 1);
    chk("R14 no char when disabled", status[0], 0);
    chk("R14 buffer untouched", rd_data, 8'hC3);
    rx_enable = 1'b1;
  endtask

  task automatic t_break_mode();
    mode = 2'b01;
    cyc(1);
    chk("R11 pin at space", serial_out, 0);
    write_byte(8'h0F);
    for (int k = 0; k < 5; k++) begin
      cyc(30);
      chk("R11 pin held during frame", serial_out, 0);
    end
    cyc(40);
    chk("R3 done in break mode", status[5], 1);
    mode = 2'b00;
    cyc(1);
    chk("R11 pin mark after mode exit", serial_out, 1);
  endtask

  initial begin
    rst_n = 1'b0; tick16 = 1'b1; mode = 2'b00; rx_enable = 1'b1;
    parity_en = 1'b0; parity_odd = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_data = '0; serial_in = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_frame();
    t_loop(8'h96, 0, 0);
    t_loop(8'h3B, 1, 1);
    t_rx_good();
    t_overrun();
    t_framing();
    t_parity();
    t_break();
    t_echo();
    t_glitch();
    t_rx_disable();
    t_break_mode();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule